// File: doc/BRIEF.md
# NAND Sub-Page Program Sequencer

This block writes a single 512-byte sub-page of a 2048-byte NAND page through a raw command/address/data bus. It accepts a host request carrying a three-byte row address and a sub-page index. It then pulls the 512 payload bytes from a valid/acknowledge byte stream and produces the complete program sequence on the bus. Each bus byte is sent with a two-clock write strobe, and the command-latch or address-latch line marks what kind of byte it is.

The program command opens the page at column zero. The block then uses a random-data-input jump to move straight to the chosen sub-page's column. It clears the attached ECC accumulator, sends the payload through it, jumps again to that sub-page's own parity field in the spare area, writes the parity bytes there, and sends the confirm command. Every other byte of the page and spare area is never driven, so it stays erased. This matters because parity computed over erased data is not itself all-ones. Done is raised only after a short settling wait and once the ready/busy line reads ready.

The ECC engine is a stand-in accumulator with clear, feed and parity-select ports. It folds byte i of the payload into parity slot i mod 14.

Top module: `nand_subpage_prog`

## Requirements
- R1: After reset, busy, done, err and both latch lines are low, and nand_we_n is high.
- R2: Each bus byte holds nand_we_n low for exactly one clock, followed by at least one high clock. Command bytes carry nand_cle=1 and nand_ale=0, address bytes carry nand_ale=1 and nand_cle=0, and data bytes carry neither. The two latch lines are never high together.
- R3: A sequence opens with command 0x80. It is followed by two address bytes 0x00, 0x00 and then the three row bytes, least significant first.
- R4: Next comes command 0x85 and the two-byte column sub×512, low byte first.
- R5: Next come the 512 payload bytes, in the order they were acknowledged. A byte is taken in a cycle where din_valid and din_ack are both high. While din_valid is low, no data strobe occurs.
- R6: The accumulator is cleared before the first payload byte, so that parity depends only on this request. Parity byte j is the XOR of the payload bytes whose index modulo 14 equals j.
- R7: After the payload come command 0x85, the two-byte column 2056+14×sub (low byte first) and the 14 parity bytes for j=0 to 13. No other bytes are sent.
- R8: The last bus byte is command 0x10. Done is a one-cycle pulse with busy low. It comes no sooner than 5 clocks after the confirm strobe and only while nand_rb is high.
- R9: A request whose sub index exceeds 3 raises err for one cycle on the next clock. It produces no strobe and leaves busy low.
- R10: Busy rises on the clock that accepts a request and stays high until done. A request presented while busy has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_row | input | 24 | Page (row) address |
| req_sub | input | 3 | Sub-page index; 0 to 3 accepted |
| din | input | 8 | Payload byte |
| din_valid | input | 1 | Payload byte available |
| din_ack | output | 1 | Payload byte taken this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Bus byte |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions assume that nand_rb stays high during the cycle in which done is produced. They also assume that the host does not tie din_valid low for ever. The bench holds ready/busy steady except for one low window, which starts after it has seen the confirm strobe. It keeps payload bytes flowing, with or without periodic gaps, so every data-phase stall ends within a few cycles. Rejected indices and requests raised during an operation are presented as one-cycle pulses, so the idle-bus and busy properties are exercised under the input behaviour they rely on.

// File: rtl/nsp_pkg.sv
// Shared definitions for the sub-page program sequencer: bus byte kinds,
// sequencer phases and the three command opcodes it issues.
package nsp_pkg;
    typedef enum logic [1:0] {BK_CMD, BK_ADR, BK_DAT} bkind_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OPEN, S_ADDR, S_JMPD, S_COLD, S_DATA,
        S_JMPE, S_COLE, S_PAR, S_CONF, S_TWB, S_WRB
    } seq_st_t;

    localparam logic [7:0] OP_PROG = 8'h80;
    localparam logic [7:0] OP_JUMP = 8'h85;
    localparam logic [7:0] OP_CONF = 8'h10;
endpackage

// File: rtl/nsp_strobe.sv
// Two-clock bus byte strobe. A byte accepted on go is shown with the write
// strobe low for one clock and then high for one clock, with the latch lines
// held for both. Assumes go is raised only while rdy is high.
module nsp_strobe
    import nsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  bkind_t     kind,
    input  logic [7:0] byte_i,
    output logic       rdy,
    output logic       we_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] io
);
    logic [1:0] ph;        // 0 idle, 1 strobe low, 2 strobe high
    bkind_t     kind_q;
    logic [7:0] io_q;

    // Phase progression and capture of the byte being sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= 2'd0;
            kind_q <= BK_DAT;
            io_q   <= 8'h00;
        end else if (go && ph != 2'd1) begin
            ph     <= 2'd1;
            kind_q <= kind;
            io_q   <= byte_i;
        end else if (ph == 2'd1) begin
            ph <= 2'd2;
        end else begin
            ph <= 2'd0;
        end
    end

    assign rdy  = (ph != 2'd1);
    assign we_n = (ph != 2'd1);
    assign cle  = (ph != 2'd0) && (kind_q == BK_CMD);
    assign ale  = (ph != 2'd0) && (kind_q == BK_ADR);
    assign io   = io_q;
endmodule

// File: rtl/nsp_ecc_acc.sv
// Stand-in for the parity engine: clear empties all slots, and each fed byte
// is XORed into the next slot, rotating through NPAR slots. Parity is read
// out combinationally by slot index. Assumes clr and feed never coincide.
module nsp_ecc_acc #(
    parameter int NPAR = 14,
    localparam int SW  = $clog2(NPAR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          feed,
    input  logic [7:0]    din,
    input  logic [SW-1:0] sel,
    output logic [7:0]    par_o
);
    localparam logic [SW-1:0] LAST = SW'(NPAR - 1);

    logic [7:0]    acc [NPAR];
    logic [SW-1:0] pos;

    // Accumulate fed bytes into the rotating slot, or clear everything
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NPAR; i++) acc[i] <= 8'h00;
            pos <= '0;
        end else if (feed) begin
            acc[pos] <= acc[pos] ^ din;
            pos      <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    assign par_o = acc[sel];
endmodule

// File: rtl/nsp_seq.sv
// Sequencer: walks the program sequence (open, row address, jump to the
// sub-page, payload, jump to its parity field, parity, confirm), then waits
// for the settling time and the ready line. Offers one byte at a time to the
// strobe unit and advances when the strobe takes it.
module nsp_seq
    import nsp_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int SUBPAGES   = 4,
    parameter int ECC_BASE   = 8,
    parameter int ECC_BYTES  = 14,
    parameter int ROW_CYCLES = 3,
    parameter int COL_CYCLES = 2,
    parameter int TWB        = 4,
    localparam int SUB_BYTES = PAGE_BYTES / SUBPAGES,
    localparam int SUB_W     = $clog2(SUBPAGES),
    localparam int ROW_W     = 8 * ROW_CYCLES,
    localparam int COL_W     = 8 * COL_CYCLES,
    localparam int PSEL_W    = $clog2(ECC_BYTES),
    localparam int CNT_W     = $clog2(SUB_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [SUB_W:0]    req_sub,
    input  logic [7:0]        din,
    input  logic              din_valid,
    input  logic              s_rdy,
    input  logic              rb,
    input  logic [7:0]        par_byte,
    output logic              din_ack,
    output logic              go,
    output bkind_t            kind,
    output logic [7:0]        byte_o,
    output logic              ecc_clr,
    output logic              ecc_feed,
    output logic [PSEL_W-1:0] par_sel,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [SUB_W:0]   SUB_LIM  = (SUB_W + 1)'(SUBPAGES);
    localparam logic [CNT_W-1:0] N_COL    = CNT_W'(COL_CYCLES);
    localparam logic [CNT_W-1:0] L_COL    = CNT_W'(COL_CYCLES - 1);
    localparam logic [CNT_W-1:0] L_ADR    = CNT_W'(COL_CYCLES + ROW_CYCLES - 1);
    localparam logic [CNT_W-1:0] L_DAT    = CNT_W'(SUB_BYTES - 1);
    localparam logic [CNT_W-1:0] L_PAR    = CNT_W'(ECC_BYTES - 1);
    localparam logic [CNT_W-1:0] L_TWB    = CNT_W'(TWB - 1);

    seq_st_t            st, nxt;
    logic [CNT_W-1:0]   cnt;
    logic [ROW_W-1:0]   row_q;
    logic [SUB_W-1:0]   sub_q;
    logic [COL_W-1:0]   col_d, col_e;
    logic [CNT_W-1:0]   cnt_row;
    logic               avail, last;

    assign col_d   = COL_W'(sub_q) * COL_W'(SUB_BYTES);
    assign col_e   = COL_W'(PAGE_BYTES + ECC_BASE) + COL_W'(sub_q) * COL_W'(ECC_BYTES);
    assign cnt_row = cnt - N_COL;

    // Byte offered in the current phase, its kind, and where the phase goes next
    always_comb begin
        avail  = 1'b1;
        kind   = BK_CMD;
        byte_o = 8'h00;
        last   = 1'b1;
        nxt    = S_IDLE;
        case (st)
            S_OPEN: begin byte_o = OP_PROG; nxt = S_ADDR; end
            S_ADDR: begin
                kind   = BK_ADR;
                byte_o = (cnt < N_COL) ? 8'h00 : 8'(row_q >> {cnt_row, 3'b000});
                last   = (cnt == L_ADR);
                nxt    = S_JMPD;
            end
            S_JMPD: begin byte_o = OP_JUMP; nxt = S_COLD; end
            S_COLD: begin
                kind   = BK_ADR;
                byte_o = 8'(col_d >> {cnt, 3'b000});
                last   = (cnt == L_COL);
                nxt    = S_DATA;
            end
            S_DATA: begin
                avail  = din_valid;
                kind   = BK_DAT;
                byte_o = din;
                last   = (cnt == L_DAT);
                nxt    = S_JMPE;
            end
            S_JMPE: begin byte_o = OP_JUMP; nxt = S_COLE; end
            S_COLE: begin
                kind   = BK_ADR;
                byte_o = 8'(col_e >> {cnt, 3'b000});
                last   = (cnt == L_COL);
                nxt    = S_PAR;
            end
            S_PAR: begin
                kind   = BK_DAT;
                byte_o = par_byte;
                last   = (cnt == L_PAR);
                nxt    = S_CONF;
            end
            S_CONF: begin byte_o = OP_CONF; nxt = S_TWB; end
            default: begin avail = 1'b0; last = 1'b0; end
        endcase
    end

    assign go       = avail && s_rdy;
    assign din_ack  = go && (st == S_DATA);
    assign ecc_feed = din_ack;
    assign ecc_clr  = go && last && (st == S_COLD);
    assign par_sel  = cnt[PSEL_W-1:0];
    assign busy     = (st != S_IDLE);

    // Phase register, byte counter, request capture and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            row_q <= '0;
            sub_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    if (req_sub < SUB_LIM) begin
                        row_q <= req_row;
                        sub_q <= req_sub[SUB_W-1:0];
                        cnt   <= '0;
                        st    <= S_OPEN;
                    end else begin
                        err <= 1'b1;
                    end
                end
                S_TWB: begin
                    if (cnt == L_TWB) begin
                        cnt <= '0;
                        st  <= S_WRB;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WRB: if (rb) begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                default: if (go) begin
                    if (last) begin
                        cnt <= '0;
                        st  <= nxt;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/nand_subpage_prog.sv
// Top level: joins the sequencer, the bus strobe unit and the parity
// accumulator. Writes one sub-page and its private spare-area parity field,
// leaving the rest of the page untouched. Assumes a write-only bus.
module nand_subpage_prog
    import nsp_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int SUBPAGES   = 4,
    parameter int ECC_BASE   = 8,
    parameter int ECC_BYTES  = 14,
    parameter int ROW_CYCLES = 3,
    parameter int COL_CYCLES = 2,
    parameter int TWB        = 4,
    localparam int SUB_W     = $clog2(SUBPAGES),
    localparam int ROW_W     = 8 * ROW_CYCLES,
    localparam int PSEL_W    = $clog2(ECC_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic [SUB_W:0]   req_sub,
    input  logic [7:0]       din,
    input  logic             din_valid,
    output logic             din_ack,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic [7:0]       nand_io,
    input  logic             nand_rb
);
    logic              s_go, s_rdy, ecc_clr, ecc_feed;
    bkind_t            s_kind;
    logic [7:0]        s_byte, par_byte;
    logic [PSEL_W-1:0] par_sel;

    nsp_seq #(
        .PAGE_BYTES(PAGE_BYTES), .SUBPAGES(SUBPAGES), .ECC_BASE(ECC_BASE),
        .ECC_BYTES(ECC_BYTES), .ROW_CYCLES(ROW_CYCLES),
        .COL_CYCLES(COL_CYCLES), .TWB(TWB)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_sub(req_sub), .din(din), .din_valid(din_valid), .s_rdy(s_rdy),
        .rb(nand_rb), .par_byte(par_byte), .din_ack(din_ack), .go(s_go),
        .kind(s_kind), .byte_o(s_byte), .ecc_clr(ecc_clr), .ecc_feed(ecc_feed),
        .par_sel(par_sel), .busy(busy), .done(done), .err(err)
    );

    nsp_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .go(s_go), .kind(s_kind), .byte_i(s_byte),
        .rdy(s_rdy), .we_n(nand_we_n), .cle(nand_cle), .ale(nand_ale),
        .io(nand_io)
    );

    nsp_ecc_acc #(.NPAR(ECC_BYTES)) u_ecc (
        .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .feed(ecc_feed), .din(din),
        .sel(par_sel), .par_o(par_byte)
    );
endmodule

// File: rtl/nsp_chk.sv
// Property checker for the sub-page program sequencer, bound to the top.
// Assumes nand_rb is held steady in the cycle done is produced.
module nsp_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_rb,
    input logic ecc_clr,
    input logic ecc_feed
);
    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> nand_we_n);

    assert_feed_is_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_feed |=> (!nand_we_n && !nand_cle && !nand_ale));

    assert_clear_on_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |=> (!nand_we_n && nand_ale));

    assert_clear_not_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |-> !ecc_feed);

    assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(nand_rb) && !busy));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nand_we_n);

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
endmodule

bind nand_subpage_prog nsp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_rb(nand_rb), .ecc_clr(ecc_clr), .ecc_feed(ecc_feed)
);

// File: tb/sim_nand_subpage_prog.sv
// Bench: behavioural expected-byte queue per request, compared on every
// clock against the bus; payload and ready/busy driven per cycle.
module sim_nand_subpage_prog;
    localparam int CLK_P = 10;
    localparam int TWB   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_row = '0;
    logic [2:0]  req_sub = '0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic        din_ack, busy, done, err;
    logic        nand_cle, nand_ale, nand_we_n, nand_rb = 1'b1;
    logic [7:0]  nand_io;

    int errors = 0;
    int checks = 0;

    logic [9:0] exq[$];
    string      exr[$];
    logic [7:0] dat [512];
    logic [7:0] par [14];

    nand_subpage_prog u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_sub(req_sub), .din(din), .din_valid(din_valid), .din_ack(din_ack),
        .busy(busy), .done(done), .err(err), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_io(nand_io),
        .nand_rb(nand_rb)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] b, input string r);
        exq.push_back({k, b});
        exr.push_back(r);
    endtask

    task automatic run_req(input logic [23:0] row, input int sub, input int pat,
                           input bit gaps, input int rb_low, input bit poke);
        int ptr = 0, cyc = 0, conf_cyc = -1;
        bit took = 0, fin = 0;
        int cole = 2056 + 14 * sub;
        for (int i = 0; i < 512; i++) begin
            case (pat)
                0: dat[i] = 8'(i);
                1: dat[i] = 8'hFF;
                2: dat[i] = 8'(i * 37 + 5);
                default: dat[i] = 8'(i ^ (i >> 3) ^ 8'h5A);
            endcase
        end
        for (int j = 0; j < 14; j++) par[j] = 8'h00;
        for (int i = 0; i < 512; i++) par[i % 14] ^= dat[i];   // R6 parity rule
        exq.delete(); exr.delete();
        push(2'b10, 8'h80, "R3");
        push(2'b01, 8'h00, "R3"); push(2'b01, 8'h00, "R3");
        push(2'b01, row[7:0], "R3"); push(2'b01, row[15:8], "R3");
        push(2'b01, row[23:16], "R3");
        push(2'b10, 8'h85, "R4");
        push(2'b01, 8'((sub * 512) & 255), "R4");
        push(2'b01, 8'((sub * 512) >> 8), "R4");
        for (int i = 0; i < 512; i++) push(2'b00, dat[i], "R5");
        push(2'b10, 8'h85, "R7");
        push(2'b01, 8'(cole & 255), "R7"); push(2'b01, 8'(cole >> 8), "R7");
        for (int j = 0; j < 14; j++) push(2'b00, par[j], "R6");
        push(2'b10, 8'h10, "R8");

        @(negedge clk);
        req_valid = 1'b1; req_row = row; req_sub = 3'(sub);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        while (!fin && cyc < 5000) begin
            if (took) ptr++;
            din       = dat[ptr < 512 ? ptr : 0];
            din_valid = (ptr < 512) && (!gaps || (cyc % 3) != 1);
            nand_rb   = !(conf_cyc >= 0 && cyc > conf_cyc && cyc <= conf_cyc + rb_low);
            req_valid = poke && (cyc == 40);
            req_row   = ~row;
            req_sub   = 3'd0;
            #1;
            took = din_ack;
            if (!nand_we_n) begin
                if (exq.size() == 0) begin
                    chk(1'b0, "R7", "extra bus byte", {nand_cle, nand_ale, nand_io}, 0);
                end else begin
                    logic [9:0] e = exq.pop_front();
                    string r = exr.pop_front();
                    chk({nand_cle, nand_ale, nand_io} == e, r, "bus byte",
                        {nand_cle, nand_ale, nand_io}, e);
                    if (e == 10'h210) conf_cyc = cyc;
                end
            end
            if (nand_cle && nand_ale) chk(1'b0, "R2", "both latches", 3, 0);
            if (!busy && !done) chk(1'b0, "R10", "busy dropped early", 0, 1);
            if (done) begin
                fin = 1;
                chk(nand_rb == 1'b1, "R8", "done while not ready", nand_rb, 1);
                chk(conf_cyc >= 0 && cyc - conf_cyc >= TWB + 1, "R8",
                    "done spacing after confirm", cyc - conf_cyc, TWB + 1);
                chk(busy == 1'b0, "R8", "busy with done", busy, 0);
            end
            @(negedge clk);
            cyc++;
        end
        din_valid = 1'b0; req_valid = 1'b0; nand_rb = 1'b1;
        chk(fin, "R8", "done reached", fin, 1);
        chk(exq.size() == 0, "R7", "bytes left unsent", exq.size(), 0);
        #1;
        chk(done == 1'b0, "R8", "done single pulse", done, 0);
    endtask

    task automatic reject(input int sub);
        bit quiet = 1;
        @(negedge clk);
        req_valid = 1'b1; req_sub = 3'(sub); req_row = 24'hABCDEF;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(err == 1'b1, "R9", "err pulse", err, 1);
        chk(busy == 1'b0, "R9", "busy on reject", busy, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (!nand_we_n || busy || err) quiet = 0;
        end
        chk(quiet, "R9", "no bus activity after reject", quiet, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(err == 0, "R1", "err", err, 0);
        chk(nand_we_n == 1, "R1", "we_n", nand_we_n, 1);
        chk(nand_cle == 0 && nand_ale == 0, "R1", "latches", {nand_cle, nand_ale}, 0);

        run_req(24'h123456, 0, 0, 1'b0, 20, 1'b0);
        run_req(24'h00A5C3, 3, 1, 1'b1, 0, 1'b0);   // R5 stalls, R8 fast ready
        run_req(24'hFEDCBA, 2, 2, 1'b0, 7, 1'b1);   // R10 request while busy
        reject(4);                                   // R9
        reject(7);
        run_req(24'h010203, 1, 3, 1'b1, 3, 1'b0);   // R6 prior parity cleared

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule